// File: doc/BRIEF.md
# Multi-rate system timing generator

The block takes one fast reference clock and produces every timing strobe the rest of the system needs, all inside that one clock domain. A two-bit prescaler gives a half-rate processor enable and a quarter-rate peripheral enable. A modulo divider on the half-rate strobe gives a slow periodic tick. With the default parameters and a 16 MHz reference these run at 8 MHz, 4 MHz and 64 kHz.

A 4-bit reloading counter advances once per quarter-rate strobe. It supplies a serial bit clock from its bit 0, a mid-rate square wave from its bit 2 and a one-cycle write pulse at each terminal count. At terminal count the counter reloads from a preset. The preset's top bit is a recording-mode input, so the write pulse rate is 500 kHz when the mode is high and 250 kHz when it is low. A second reloading counter has a fixed preset set by a parameter. Its upper half of the count range gives a low-frequency rate square wave.

Top module: `sysclk_gen`

## Requirements
- R1: While rst_ni is low every output is 0. The first rising edge after reset release starts all dividers from a count of zero.
- R2: sys_en_o is a one-cycle pulse every 2 clk_i cycles and per_en_o is a one-cycle pulse every 4 cycles. per_en_o is never high without sys_en_o. The first per_en_o appears after the 4th edge following reset release.
- R3: lf_tick_o is a one-cycle pulse with a period of 2*SLOW_DIV clk_i cycles (250 by default).
- R4: The write counter changes only in the cycle where per_en_o is high. ser_clk_o is its bit 0, giving a square wave with a period of 8 clk_i cycles. mid_clk_o is its bit 2, with a period of 32 clk_i cycles in both modes.
- R5: When the write counter is at 15 on a quarter-rate strobe, it reloads from a preset whose bit 3 is dense_mode_i and whose other bits are 0. wr_tick_o is high for exactly that one cycle, together with per_en_o.
- R6: The spacing between wr_tick_o pulses is 32 clk_i cycles with dense_mode_i high (counts 8 to 15) and 64 cycles with it low (counts 0 to 15).
- R7: dense_mode_i is sampled only at a reload. A change between reloads leaves the current write period at its old length, and the new length applies from the following period.
- R8: The rate counter reloads from RATE_PRESET (default 6) and steps on each quarter-rate strobe. rate_o is high while the count is in the upper half (8 to 15), giving a period of 4*(16-RATE_PRESET) clk_i cycles (40 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dense_mode_i | input | 1 | Recording mode: 1 selects the fast write rate |
| sys_en_o | output | 1 | Half-rate enable pulse |
| per_en_o | output | 1 | Quarter-rate enable pulse |
| lf_tick_o | output | 1 | Slow tick pulse |
| ser_clk_o | output | 1 | Serial bit clock, write counter bit 0 |
| mid_clk_o | output | 1 | Mid-rate square wave, write counter bit 2 |
| wr_tick_o | output | 1 | Write clock pulse at each reload |
| rate_o | output | 1 | Low-frequency rate square wave |

## Verification
On every cycle the assertions check the following. The half-rate and write pulses are single-cycle. The quarter-rate strobe implies the half-rate strobe. The serial, mid-rate and rate outputs move only on a quarter-rate strobe. A write pulse comes with that strobe, and its spacing is always either 32 or 64 cycles. The bench's scenarios are needed to show which spacing belongs to which mode. They also show that a mode change in mid-period keeps the old length for the current period. The exact periods of the slow tick and the rate wave are measured there too.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  localparam int unsigned CTR_W       = 4;
  localparam int unsigned PRE_W       = 2;
  localparam int unsigned DEF_SLOW    = 125;
  localparam int unsigned DEF_RATE_PS = 6;
  typedef logic [CTR_W-1:0] nib_t;
endpackage

// File: rtl/sysclk_prescale.sv
module sysclk_prescale #(
  parameter int unsigned PW = sysclk_pkg::PRE_W
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic half_stb_o,
  output logic quart_stb_o,
  output logic half_en_o,
  output logic quart_en_o
);
  localparam logic [PW-1:0] ALL1 = '1;
  logic [PW-1:0] pre_q;

  assign half_stb_o  = pre_q[0];
  assign quart_stb_o = (pre_q == ALL1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q      <= '0;
      half_en_o  <= 1'b0;
      quart_en_o <= 1'b0;
    end else begin
      pre_q      <= pre_q + 1'b1;
      half_en_o  <= half_stb_o;
      quart_en_o <= quart_stb_o;
    end
  end
endmodule

// File: rtl/sysclk_tick_div.sv
module sysclk_tick_div #(
  parameter int unsigned DIV = sysclk_pkg::DEF_SLOW
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (en_i) begin
      if (cnt_q == LAST) begin
        cnt_q  <= '0;
        tick_o <= 1'b1;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
        tick_o <= 1'b0;
      end
    end else begin
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sysclk_reload_ctr.sv
module sysclk_reload_ctr #(
  parameter int unsigned CW = sysclk_pkg::CTR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [CW-1:0] preset_i,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] TC = '1;

  // terminal count loads the preset on the same strobe instead of wrapping
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_o <= '0;
    else if (en_i)      cnt_o <= (cnt_o == TC) ? preset_i : cnt_o + 1'b1;
  end
endmodule

// File: rtl/sysclk_gen.sv
module sysclk_gen #(
  parameter int unsigned SLOW_DIV    = sysclk_pkg::DEF_SLOW,
  parameter int unsigned RATE_PRESET = sysclk_pkg::DEF_RATE_PS
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dense_mode_i,
  output logic sys_en_o,
  output logic per_en_o,
  output logic lf_tick_o,
  output logic ser_clk_o,
  output logic mid_clk_o,
  output logic wr_tick_o,
  output logic rate_o
);
  import sysclk_pkg::*;
  localparam int unsigned CW = CTR_W;
  localparam nib_t TC     = '1;
  localparam nib_t HALF   = nib_t'(1) << (CW - 1);
  localparam nib_t RATE_P = nib_t'(RATE_PRESET);

  logic half_stb, quart_stb;
  nib_t wr_cnt, rate_cnt, wr_preset;

  sysclk_prescale #(.PW(PRE_W)) u_pre (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .half_stb_o  (half_stb),
    .quart_stb_o (quart_stb),
    .half_en_o   (sys_en_o),
    .quart_en_o  (per_en_o)
  );

  sysclk_tick_div #(.DIV(SLOW_DIV)) u_slow (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (half_stb),
    .tick_o (lf_tick_o)
  );

  always_comb begin
    wr_preset         = '0;
    wr_preset[CW-1]   = dense_mode_i;
  end

  sysclk_reload_ctr #(.CW(CW)) u_wr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (quart_stb),
    .preset_i (wr_preset),
    .cnt_o    (wr_cnt)
  );

  sysclk_reload_ctr #(.CW(CW)) u_rate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (quart_stb),
    .preset_i (RATE_P),
    .cnt_o    (rate_cnt)
  );

  assign ser_clk_o = wr_cnt[0];
  assign mid_clk_o = wr_cnt[2];
  assign rate_o    = (rate_cnt >= HALF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_tick_o <= 1'b0;
    else         wr_tick_o <= quart_stb && (wr_cnt == TC);
  end
endmodule

// File: rtl/sysclk_gen_chk.sv
module sysclk_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic dense_mode_i,
  input logic sys_en_o,
  input logic per_en_o,
  input logic lf_tick_o,
  input logic ser_clk_o,
  input logic mid_clk_o,
  input logic wr_tick_o,
  input logic rate_o
);
  logic [7:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        gap_q <= '0;
    else if (wr_tick_o) gap_q <= 8'd1;
    else if (gap_q != 8'hff) gap_q <= gap_q + 1'b1;
  end

  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> !(sys_en_o || per_en_o || lf_tick_o || wr_tick_o || ser_clk_o || mid_clk_o || rate_o));
  a_r2_per_has_sys: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_en_o |-> sys_en_o);
  a_r2_sys_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_en_o |=> !sys_en_o);
  a_r3_lf_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lf_tick_o |=> !lf_tick_o);
  a_r4_ser_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ser_clk_o) |-> per_en_o);
  a_r4_mid_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mid_clk_o) |-> per_en_o);
  a_r5_tick_with_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_tick_o |-> per_en_o);
  a_r5_tick_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_tick_o |=> !wr_tick_o);
  a_r6_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_tick_o |-> (gap_q == 8'd32 || gap_q == 8'd64));
  a_r8_rate_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rate_o) |-> per_en_o);
endmodule

bind sysclk_gen sysclk_gen_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .dense_mode_i (dense_mode_i),
  .sys_en_o     (sys_en_o),
  .per_en_o     (per_en_o),
  .lf_tick_o    (lf_tick_o),
  .ser_clk_o    (ser_clk_o),
  .mid_clk_o    (mid_clk_o),
  .wr_tick_o    (wr_tick_o),
  .rate_o       (rate_o)
);

// File: tb/sysclk_gen_bench.sv
`timescale 1ns/1ps
module sysclk_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dense = 1'b0;
  logic sys_en, per_en, lf_tick, ser_clk, mid_clk, wr_tick, rate;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sysclk_gen u_sysclk_gen (
    .clk_i(clk), .rst_ni(rst_n), .dense_mode_i(dense),
    .sys_en_o(sys_en), .per_en_o(per_en), .lf_tick_o(lf_tick),
    .ser_clk_o(ser_clk), .mid_clk_o(mid_clk), .wr_tick_o(wr_tick), .rate_o(rate)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: got %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  // behavioural reference: integer phase and counts stepped on each edge
  int m_ph = 0, m_slow = 0, m_wr = 0, m_rt = 0;
  int e_sys = 0, e_per = 0, e_lf = 0, e_wt = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_slow = 0; m_wr = 0; m_rt = 0;
      e_sys = 0; e_per = 0; e_lf = 0; e_wt = 0;
    end else begin
      e_sys = (m_ph % 2 == 1);
      e_per = (m_ph == 3);
      e_lf = 0;
      if (e_sys) begin
        if (m_slow == 124) begin m_slow = 0; e_lf = 1; end
        else m_slow++;
      end
      e_wt = e_per && (m_wr == 15);
      if (e_per) begin
        m_wr = (m_wr == 15) ? (dense ? 8 : 0) : m_wr + 1;
        m_rt = (m_rt == 15) ? 6 : m_rt + 1;
      end
      m_ph = (m_ph + 1) % 4;
    end
  end

  int wr_last = 0, wr_gap = 0, wr_n = 0;
  int lf_last = 0, lf_gap = 0, lf_n = 0;
  int se_last = 0, se_gap = 0, se_n = 0;
  int mi_last = 0, mi_gap = 0, mi_n = 0;
  int ra_last = 0, ra_gap = 0, ra_n = 0;
  logic se_p = 0, mi_p = 0, ra_p = 0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      cyc++;
      chk("R2 sys_en", sys_en, e_sys);
      chk("R2 per_en", per_en, e_per);
      chk("R3 lf_tick", lf_tick, e_lf);
      chk("R4 ser_clk", ser_clk, m_wr % 2);
      chk("R4 mid_clk", mid_clk, (m_wr / 4) % 2);
      chk("R5 wr_tick", wr_tick, e_wt);
      chk("R8 rate", rate, m_rt >= 8);
      if (wr_tick) begin wr_gap = cyc - wr_last; wr_last = cyc; wr_n++; end
      if (lf_tick) begin lf_gap = cyc - lf_last; lf_last = cyc; lf_n++; end
      if (ser_clk && !se_p) begin se_gap = cyc - se_last; se_last = cyc; se_n++; end
      if (mid_clk && !mi_p) begin mi_gap = cyc - mi_last; mi_last = cyc; mi_n++; end
      if (rate && !ra_p) begin ra_gap = cyc - ra_last; ra_last = cyc; ra_n++; end
      se_p = ser_clk; mi_p = mid_clk; ra_p = rate;
    end
  end

  task automatic next_wr(output int g);
    int n0 = wr_n;
    while (wr_n == n0) begin @(negedge clk); #1; end
    g = wr_gap;
  endtask

  initial begin
    int g;
    fork
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
      begin
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        chk("R1 reset outputs", {sys_en, per_en, lf_tick, ser_clk, mid_clk, wr_tick, rate}, 0);
        rst_n = 1'b1;
        // R5/R6 low mode: first pulse at 64 cycles, then 64 apart
        next_wr(g); chk("R5 first write pulse cycle", wr_last, 64);
        next_wr(g); chk("R6 low-mode spacing", g, 64);
        // R7 raise mode mid-period
        repeat (20) @(negedge clk);
        #1 dense = 1'b1;
        next_wr(g); chk("R7 period in progress kept", g, 64);
        next_wr(g); chk("R6 dense spacing", g, 32);
        next_wr(g); chk("R6 dense spacing repeat", g, 32);
        // R7 drop mode mid-period
        repeat (10) @(negedge clk);
        #1 dense = 1'b0;
        next_wr(g); chk("R7 dense period kept", g, 32);
        next_wr(g); chk("R7 new low period", g, 64);
        // periodic outputs
        while (lf_n < 3) begin @(negedge clk); #1; end
        chk("R3 slow tick spacing", lf_gap, 250);
        chk("R4 ser rise spacing", se_gap, 8);
        chk("R4 mid rise spacing", mi_gap, 32);
        chk("R8 rate rise spacing", ra_gap, 40);
        #1 dense = 1'b1;
        next_wr(g); next_wr(g);
        chk("R4 mid rise spacing dense", mi_gap, 32);
        // R1 async reset mid-run
        #1 rst_n = 1'b0;
        #1;
        chk("R1 reset clears outputs", {sys_en, per_en, lf_tick, ser_clk, mid_clk, wr_tick, rate}, 0);
      end
    join_any
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule